// File: doc/BRIEF.md
# Two-Sided Issue Lag Controller

This block controls a split instruction issue path that has a left half and a right half. Each half owns a private lag counter. A half is held back while its counter is nonzero. The counter falls by one on every issue clock, and the half issues once it reaches zero. Decoders add lag to either half at any time. The relative contents of the two counters therefore decide which half resumes first. Equal contents make both halves resume on the same cycle.

On a call, the controller pushes the pair of lag values onto a small internal stack. The matching return pops the pair and loads it back into both counters, so a callee's lag history does not leak into the caller. Stack misuse sets a sticky error flag. Misuse means a call when the stack is full, or a return when it is empty.

Every pin is a plain level or single-cycle pulse. Issue is not a data stream, so there is no valid/ready handshake and no back-pressure. A half that lags simply sees its issue enable low.

Top module: `issue_lag_ctrl`

## Requirements
- R1: The two counters are independent. An increment, countdown or saturation on one side never changes the other side's counter.
- R2: With no increment, no return and no reset, a nonzero counter decreases by exactly one on every rising clock edge, and a zero counter stays zero.
- R3: The next counter value is max(old-1, 0) plus the increment, saturating at 2^LAG_W-1. An increment of zero means no added lag.
- R4: `issue_l` is high exactly when `lag_l` is zero, and `issue_r` is high exactly when `lag_r` is zero.
- R5: Lags that are equal and receive no further increments reach zero on the same cycle. For example, loading left 1 and right 2 gives: the first cycle with both halves stalled; the next cycle with left issuing and right stalled; the third cycle with both issuing.
- R6: A call (`call_i` high, `ret_i` low) pushes the pair of counter values present before that edge. In that same cycle, both counters still update as in R3.
- R7: A return (`ret_i` high, `call_i` low) loads both counters from the most recently pushed pair and removes that pair from the stack. The return overrides that cycle's countdown and increments.
- R8: The stack holds DEPTH (8) pairs. A call with DEPTH pairs stored pushes nothing. A return on an empty stack loads zeros into both counters. Either case sets `stack_err`, which stays high until reset.
- R9: When `call_i` and `ret_i` are high together, the stack and `stack_err` are unchanged, and the counters update as in R3.
- R10: A synchronous reset clears both counters, empties the stack and clears `stack_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Issue clock |
| rst | input | 1 | Synchronous active-high reset |
| inc_l | input | LAG_W | Lag added to the left half this cycle |
| inc_r | input | LAG_W | Lag added to the right half this cycle |
| call_i | input | 1 | Call pulse: save both lags |
| ret_i | input | 1 | Return pulse: restore both lags |
| issue_l | output | 1 | Left half may issue |
| issue_r | output | 1 | Right half may issue |
| lag_l | output | LAG_W | Current left lag |
| lag_r | output | LAG_W | Current right lag |
| stack_err | output | 1 | Sticky stack overflow/underflow flag |

## Verification
The assertions take for granted two things about the inputs. First, the increments, `call_i` and `ret_i` are defined (never X) on every edge after reset. Second, reset is held for at least one edge before the first real cycle, so that each `$past` term refers to a cleared counter or stack pointer. The stimulus drives every input from the falling edge, starting from a held reset. It then mixes directed sequences with random traffic. The random traffic uses mostly small increments and sparse call and return pulses. It deliberately includes simultaneous call/return, saturating increments, and runs past both ends of the stack.

// File: rtl/lag_pkg.sv
package lag_pkg;
  typedef enum logic [1:0] {
    STK_IDLE = 2'd0,
    STK_PUSH = 2'd1,
    STK_POP  = 2'd2
  } stk_op_e;
endpackage

// File: rtl/lag_side.sv
module lag_side #(
  parameter int LAG_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LAG_W-1:0] inc,
  input  logic             load,
  input  logic [LAG_W-1:0] load_val,
  output logic [LAG_W-1:0] lag,
  output logic             issue
);
  localparam logic [LAG_W-1:0] MAXV = {LAG_W{1'b1}};

  logic [LAG_W-1:0] lag_q;
  logic [LAG_W-1:0] base;
  logic [LAG_W:0]   sum;
  logic [LAG_W-1:0] nxt;

  always_comb begin
    base = (lag_q != '0) ? lag_q - 1'b1 : '0;
    sum  = {1'b0, base} + {1'b0, inc};
    nxt  = sum[LAG_W] ? MAXV : sum[LAG_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)       lag_q <= '0;
    else if (load) lag_q <= load_val;
    else           lag_q <= nxt;
  end

  assign lag   = lag_q;
  assign issue = (lag_q == '0);

  // R2: plain countdown by one
  a_r2_countdown: assert property (@(posedge clk) disable iff (rst)
    (!load && lag_q != '0 && inc == '0) |=> (lag_q == $past(lag_q) - 1'b1));
  // R2: zero holds without increment
  a_r2_zero_hold: assert property (@(posedge clk) disable iff (rst)
    (!load && lag_q == '0 && inc == '0) |=> (lag_q == '0));
  // R3: result never below the added amount
  a_r3_floor: assert property (@(posedge clk) disable iff (rst)
    (!load) |=> (lag_q >= $past(inc)));
  // R7: restore loads the saved value
  a_r7_load: assert property (@(posedge clk) disable iff (rst)
    load |=> (lag_q == $past(load_val)));
endmodule

// File: rtl/lag_stack.sv
module lag_stack #(
  parameter int LAG_W = 4,
  parameter int DEPTH = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               call,
  input  logic               ret,
  input  logic [2*LAG_W-1:0] wdata,
  output logic [2*LAG_W-1:0] rdata,
  output logic               err
);
  import lag_pkg::*;

  localparam int PW = $clog2(DEPTH + 1);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] FULLV = PW'(DEPTH);

  logic [2*LAG_W-1:0] mem [DEPTH];
  logic [PW-1:0]      ptr;
  logic               full, empty;
  stk_op_e            op;

  assign full  = (ptr == FULLV);
  assign empty = (ptr == '0);

  always_comb begin
    if (call && !ret)      op = STK_PUSH;
    else if (ret && !call) op = STK_POP;
    else                   op = STK_IDLE;
  end

  assign rdata = empty ? '0 : mem[AW'(ptr - 1'b1)];

  always_ff @(posedge clk) begin
    if (!rst && op == STK_PUSH && !full) mem[AW'(ptr)] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
      err <= 1'b0;
    end else begin
      case (op)
        STK_PUSH: if (full)  err <= 1'b1; else ptr <= ptr + 1'b1;
        STK_POP:  if (empty) err <= 1'b1; else ptr <= ptr - 1'b1;
        default: ;
      endcase
    end
  end

  // R8: flag is sticky
  a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
    err |=> err);
  // R8: pointer never exceeds depth
  a_r8_bound: assert property (@(posedge clk) disable iff (rst)
    ptr <= FULLV);
  // R8: overflow raises the flag and does not move the pointer
  a_r8_overflow: assert property (@(posedge clk) disable iff (rst)
    (op == STK_PUSH && full) |=> (err && $stable(ptr)));
  // R6: accepted call grows the stack by one
  a_r6_push: assert property (@(posedge clk) disable iff (rst)
    (op == STK_PUSH && !full) |=> (ptr == $past(ptr) + 1'b1));
  // R9: simultaneous call and return leave the stack alone
  a_r9_both: assert property (@(posedge clk) disable iff (rst)
    (call && ret) |=> ($stable(ptr) && err == $past(err)));
endmodule

// File: rtl/issue_lag_ctrl.sv
module issue_lag_ctrl #(
  parameter int LAG_W = 4,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LAG_W-1:0] inc_l,
  input  logic [LAG_W-1:0] inc_r,
  input  logic             call_i,
  input  logic             ret_i,
  output logic             issue_l,
  output logic             issue_r,
  output logic [LAG_W-1:0] lag_l,
  output logic [LAG_W-1:0] lag_r,
  output logic             stack_err
);
  localparam int SIDES = 2;

  logic [LAG_W-1:0]   inc_a [SIDES];
  logic [LAG_W-1:0]   lag_a [SIDES];
  logic [LAG_W-1:0]   ld_a  [SIDES];
  logic               iss_a [SIDES];
  logic [2*LAG_W-1:0] saved;
  logic               restore;

  assign restore  = ret_i && !call_i;
  assign inc_a[0] = inc_l;
  assign inc_a[1] = inc_r;

  lag_stack #(.LAG_W(LAG_W), .DEPTH(DEPTH)) u_stack (
    .clk   (clk),
    .rst   (rst),
    .call  (call_i),
    .ret   (ret_i),
    .wdata ({lag_a[1], lag_a[0]}),
    .rdata (saved),
    .err   (stack_err)
  );

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    assign ld_a[s] = saved[s*LAG_W +: LAG_W];
    lag_side #(.LAG_W(LAG_W)) u_side (
      .clk      (clk),
      .rst      (rst),
      .inc      (inc_a[s]),
      .load     (restore),
      .load_val (ld_a[s]),
      .lag      (lag_a[s]),
      .issue    (iss_a[s])
    );
  end

  assign lag_l   = lag_a[0];
  assign lag_r   = lag_a[1];
  assign issue_l = iss_a[0];
  assign issue_r = iss_a[1];

  // R5: equal lags with no new input keep issue in step
  a_r5_equal: assert property (@(posedge clk) disable iff (rst)
    (lag_l == lag_r && inc_l == inc_r && !restore) |=> (issue_l == issue_r));
  // R1: right counter untouched by left activity when idle
  a_r1_indep: assert property (@(posedge clk) disable iff (rst)
    (lag_r == '0 && inc_r == '0 && !restore) |=> (lag_r == '0));
  // R4: issue enables follow the counters
  a_r4_issue: assert property (@(posedge clk) disable iff (rst)
    (issue_l == (lag_l == '0)) && (issue_r == (lag_r == '0)));
endmodule

// File: tb/tb_issue_lag_ctrl.sv
module tb_issue_lag_ctrl;
  localparam int LAG_W = 4;
  localparam int DEPTH = 8;
  localparam int MAXV  = (1 << LAG_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [LAG_W-1:0] inc_l = '0, inc_r = '0;
  logic call_i = 1'b0, ret_i = 1'b0;
  logic issue_l, issue_r, stack_err;
  logic [LAG_W-1:0] lag_l, lag_r;

  always #10 clk = ~clk;

  issue_lag_ctrl #(.LAG_W(LAG_W), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .inc_l(inc_l), .inc_r(inc_r),
    .call_i(call_i), .ret_i(ret_i), .issue_l(issue_l), .issue_r(issue_r),
    .lag_l(lag_l), .lag_r(lag_r), .stack_err(stack_err));

  int compared = 0, mismatched = 0;
  int ml = 0, mr = 0, merr = 0;
  int ql[$], qr[$];
  bit done = 0;
  string phase = "R10_reset";

  task automatic check(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s [%s] actual=%0d expected=%0d", tag, phase, act, exp);
    end
  endtask

  function automatic int nextv(input int v, input int inc);
    int t;
    t = ((v > 0) ? v - 1 : 0) + inc;
    return (t > MAXV) ? MAXV : t;
  endfunction

  task automatic compare_all();
    check("R2 R3 lag_l", int'(lag_l), ml);
    check("R2 R3 lag_r", int'(lag_r), mr);
    check("R4 issue_l", int'(issue_l), (ml == 0) ? 1 : 0);
    check("R4 issue_r", int'(issue_r), (mr == 0) ? 1 : 0);
    check("R8 stack_err", int'(stack_err), merr);
  endtask

  // compare current state, drive inputs, advance model, wait one cycle
  task automatic cycle(input int il, input int ir, input bit c, input bit r);
    int nl, nr;
    compare_all();
    inc_l = LAG_W'(il); inc_r = LAG_W'(ir); call_i = c; ret_i = r;
    nl = nextv(ml, il); nr = nextv(mr, ir);
    if (c && !r) begin
      if (ql.size() < DEPTH) begin ql.push_back(ml); qr.push_back(mr); end
      else merr = 1;
    end else if (r && !c) begin
      if (ql.size() > 0) begin nl = ql.pop_back(); nr = qr.pop_back(); end
      else begin nl = 0; nr = 0; merr = 1; end
    end
    ml = nl; mr = nr;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R10 reset lag_l", int'(lag_l), 0);
    check("R10 reset err", int'(stack_err), 0);

    phase = "R5_example";
    cycle(1, 2, 0, 0);
    check("R5 both stall l", int'(issue_l), 0);
    check("R5 both stall r", int'(issue_r), 0);
    cycle(0, 0, 0, 0);
    check("R5 left issues", int'(issue_l), 1);
    check("R5 right stalls", int'(issue_r), 0);
    cycle(0, 0, 0, 0);
    check("R5 both issue l", int'(issue_l), 1);
    check("R5 both issue r", int'(issue_r), 1);
    cycle(3, 3, 0, 0);
    repeat (2) cycle(0, 0, 0, 0);
    check("R5 equal in step", int'(issue_l), int'(issue_r));
    repeat (2) cycle(0, 0, 0, 0);

    phase = "R1_independent";
    cycle(5, 0, 0, 0);
    check("R1 right untouched", int'(lag_r), 0);
    check("R1 left loaded", int'(lag_l), 5);
    phase = "R3_saturate";
    cycle(15, 0, 0, 0);
    check("R3 saturates", int'(lag_l), MAXV);
    cycle(4, 7, 0, 0);
    check("R3 overlap", int'(lag_l), MAXV);
    check("R3 right add", int'(lag_r), 7);

    phase = "R6_R7_call_ret";
    cycle(0, 0, 1, 0);
    repeat (3) cycle(0, 0, 0, 0);
    cycle(0, 0, 0, 1);
    check("R7 restore l", int'(lag_l), MAXV);
    check("R7 restore r", int'(lag_r), 7);

    phase = "R9_both";
    cycle(2, 2, 1, 1);
    cycle(0, 0, 0, 1);
    check("R9 empty after pair", int'(stack_err), 1);

    phase = "R10_reset2";
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    ml = 0; mr = 0; merr = 0; ql.delete(); qr.delete();
    check("R10 err cleared", int'(stack_err), 0);

    phase = "R8_overflow";
    for (int i = 0; i < DEPTH + 1; i++) cycle(i % 4, (i + 1) % 4, 1, 0);
    check("R8 overflow flag", int'(stack_err), 1);
    for (int i = 0; i < DEPTH + 2; i++) cycle(0, 0, 0, 1);
    check("R8 underflow zeros", int'(lag_l) + int'(lag_r), 0);

    phase = "random";
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    ml = 0; mr = 0; merr = 0; ql.delete(); qr.delete();
    for (int i = 0; i < 4000; i++) begin
      int il, ir, pc;
      il = ($urandom_range(0, 3) == 0) ? $urandom_range(0, MAXV) : 0;
      ir = ($urandom_range(0, 3) == 0) ? $urandom_range(0, MAXV) : 0;
      pc = $urandom_range(0, 19);
      cycle(il, ir, pc == 0 || pc == 2, pc == 1 || pc == 2);
    end
    compare_all();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL R10 watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule